// File: doc/BRIEF.md
# Multiphase Collection Gate Pulse Sequencer

This block produces the six gate-drive signals of one pixel cluster: five collection-gate strobes and one drain-gate level. It is a synchronous, clocked version of a multiphase oscillator driver. A six-stage twisted-ring (Johnson) register steps once per clock, so it passes through twelve phases. Each phase tap is high for exactly six of those twelve clocks, so every tap has a 50% duty cycle. Each collection strobe combines one tap with the complement of the next tap through an XNOR. The result is qualified by the polarity of the first tap, so every strobe is exactly one clock wide and no two strobes overlap.

The drain output decides when charge is collected. It is driven high whenever collection is stopped, which dumps charge into the drain. It is driven low while collection runs. A capture-window request opens and closes collection, but the request is only acted on at the ring's wrap point. Collection therefore always spans whole ring cycles, and no strobe is ever cut short. Dropping the enable aborts collection at once and clears the ring.

The controller has three states:
- **SEQ_OFF**: enable is low and the ring is held at zero.
- **SEQ_IDLE**: the ring runs and the drain is high.
- **SEQ_COLLECT**: strobes are issued and the drain is low.

Its transitions are:
- **power-up**: any state goes to SEQ_OFF while enable is low.
- **start-ring**: SEQ_OFF goes to SEQ_IDLE once enable is high.
- **open-window**: SEQ_IDLE goes to SEQ_COLLECT when the request is high at the wrap phase.
- **close-window**: SEQ_COLLECT goes to SEQ_IDLE when the request is low at the wrap phase.

Top module: `cg_pulse_seq`

## Requirements
- R1: After synchronous reset, every collection output is low and the drain output is high, and the ring holds all zeros.
- R2: The phase is the number of rising clock edges with `en` high since `en` was last low or since reset, taken modulo 12. While `en` is low, the phase is forced to 0.
- R3: While collection is running, each collection output is high in exactly one clock out of every 12.
- R4: Collection output bit k-1 (gate k, k = 1..5) is high only when collection is active and the phase is k. The gates therefore fire in ascending order on consecutive clocks, each for one clock.
- R5: At most one of the six outputs (`cg_drive` bits and `drain_drive`) is high in any cycle.
- R6: `drain_drive` is low exactly while collection is active and high at all other times.
- R7: Collection starts only at phase 0. It starts on the clock edge that leaves phase 11, and only if `win_req` is high at that edge. A request seen at any other phase has no effect.
- R8: Collection stops only at phase 0. It stops on the clock edge that leaves phase 11 with `win_req` low. Dropping `win_req` at other phases does not end a cycle early.
- R9: When `en` is low, all collection outputs are low and `drain_drive` is high within the same cycle (combinationally), and the controller returns to its off state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock at twelve times the strobe rate |
| rst | input | 1 | Synchronous reset, active high |
| en | input | 1 | Run enable; low clears the ring and stops collection |
| win_req | input | 1 | Capture-window request, sampled at the wrap phase |
| cg_drive | output | 5 | Collection-gate strobes, bit k-1 drives gate k |
| drain_drive | output | 1 | Drain-gate level, low while collecting |

## Verification
The hardest case to reach is a window request that changes at a phase other than 11. For example, the request may rise at phase 10 and fall again before the wrap, or fall mid-cycle during collection. The design must ignore such changes, and a bench that only toggles the request at convenient points never tries them. The stimulus sweeps the request's opening and closing across all twelve phase offsets. A long run then follows in which a bench LFSR toggles the request and occasionally drops the enable. Every cycle is compared against a phase counter kept modulo 12 in the bench.

// File: rtl/cg_seq_pkg.sv
package cg_seq_pkg;
    typedef enum logic [1:0] {
        SEQ_OFF     = 2'd0,
        SEQ_IDLE    = 2'd1,
        SEQ_COLLECT = 2'd2
    } seq_state_t;
endpackage

// File: rtl/johnson_ring.sv
module johnson_ring #(
    parameter int STAGES = 6
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              run,
    output logic [STAGES-1:0] ring,
    output logic              wrap
);
    // Twisted ring: stage 0 takes the inverse of the last stage.
    always_ff @(posedge clk) begin
        if (rst || !run) begin
            ring <= '0;
        end else begin
            ring <= {ring[STAGES-2:0], ~ring[STAGES-1]};
        end
    end

    // Last phase of the 2*STAGES cycle: only the top stage is set.
    assign wrap = ring[STAGES-1] & ~ring[STAGES-2];
endmodule

// File: rtl/tap_decoder.sv
module tap_decoder #(
    parameter int STAGES = 6,
    localparam int NGATE = STAGES - 1
) (
    input  logic [STAGES-1:0] ring,
    input  logic              gate,
    output logic [NGATE-1:0]  cg
);
    logic [STAGES-1:0] ring_n;
    assign ring_n = ~ring;

    // Tap k is XNORed with the complementary tap k+1. The result is
    // qualified by tap k's polarity, so only the leading transition counts.
    for (genvar k = 0; k < NGATE; k++) begin : g_gate
        logic diff;
        assign diff  = ring[k] ~^ ring_n[k+1];
        assign cg[k] = gate & ring[k] & diff;
    end
endmodule

// File: rtl/window_fsm.sv
module window_fsm
    import cg_seq_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic en,
    input  logic win_req,
    input  logic wrap,
    output logic collect
);
    seq_state_t state, state_nx;

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= SEQ_OFF;
        end else begin
            state <= state_nx;
        end
    end

    always_comb begin
        state_nx = state;
        if (!en) begin
            state_nx = SEQ_OFF;
        end else begin
            unique case (state)
                SEQ_OFF:     state_nx = SEQ_IDLE;
                SEQ_IDLE:    if (wrap && win_req)  state_nx = SEQ_COLLECT;
                SEQ_COLLECT: if (wrap && !win_req) state_nx = SEQ_IDLE;
                default:     state_nx = SEQ_OFF;
            endcase
        end
    end

    always_comb begin
        collect = (state == SEQ_COLLECT) && en;
    end
endmodule

// File: rtl/cg_pulse_seq.sv
module cg_pulse_seq #(
    parameter int STAGES = 6,
    localparam int NGATE = STAGES - 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             en,
    input  logic             win_req,
    output logic [NGATE-1:0] cg_drive,
    output logic             drain_drive
);
    logic [STAGES-1:0] ring_q;
    logic              wrap;
    logic              collect;

    johnson_ring #(.STAGES(STAGES)) u_ring (
        .clk  (clk),
        .rst  (rst),
        .run  (en),
        .ring (ring_q),
        .wrap (wrap)
    );

    window_fsm u_fsm (
        .clk     (clk),
        .rst     (rst),
        .en      (en),
        .win_req (win_req),
        .wrap    (wrap),
        .collect (collect)
    );

    tap_decoder #(.STAGES(STAGES)) u_dec (
        .ring (ring_q),
        .gate (collect),
        .cg   (cg_drive)
    );

    assign drain_drive = ~collect;
endmodule

// File: rtl/cg_pulse_seq_chk.sv
module cg_pulse_seq_chk #(
    parameter int STAGES = 6,
    localparam int NGATE = STAGES - 1
) (
    input logic             clk,
    input logic             rst,
    input logic             en,
    input logic [NGATE-1:0] cg_drive,
    input logic             drain_drive,
    input logic [STAGES-1:0] ring
);
    p_one_hot_r5: assert property (@(posedge clk) disable iff (rst)
        $onehot0({drain_drive, cg_drive}));

    p_off_quiet_r9: assert property (@(posedge clk) disable iff (rst)
        !en |-> (drain_drive && cg_drive == '0));

    p_ring_clear_r2: assert property (@(posedge clk) disable iff (rst)
        !en |=> ring == '0);

    p_ring_twist_r3: assert property (@(posedge clk) disable iff (rst)
        en |=> ring[0] == !$past(ring[STAGES-1]));

    p_start_aligned_r7: assert property (@(posedge clk) disable iff (rst)
        $fell(drain_drive) |-> ring == '0);

    p_stop_aligned_r8: assert property (@(posedge clk) disable iff (rst)
        ($rose(drain_drive) && en) |-> ring == '0);

    p_first_gate_r4: assert property (@(posedge clk) disable iff (rst)
        $fell(drain_drive) |=> (cg_drive[0] || !en));

    p_drain_low_r6: assert property (@(posedge clk) disable iff (rst)
        (cg_drive != '0) |-> !drain_drive);

    for (genvar k = 1; k < NGATE; k++) begin : g_order
        p_order_r4: assert property (@(posedge clk) disable iff (rst)
            cg_drive[k] |-> $past(cg_drive[k-1]));
    end
endmodule

bind cg_pulse_seq cg_pulse_seq_chk #(.STAGES(STAGES)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .en          (en),
    .cg_drive    (cg_drive),
    .drain_drive (drain_drive),
    .ring        (ring_q)
);

// File: tb/cg_pulse_seq_test.sv
module cg_pulse_seq_test;
    localparam int STAGES = 6;
    localparam int NGATE  = STAGES - 1;
    localparam int PERIOD = 2 * STAGES;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             en = 1'b0;
    logic             win_req = 1'b0;
    logic [NGATE-1:0] cg_drive;
    logic             drain_drive;

    int errors = 0;
    int checks = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    cg_pulse_seq #(.STAGES(STAGES)) uut (
        .clk         (clk),
        .rst         (rst),
        .en          (en),
        .win_req     (win_req),
        .cg_drive    (cg_drive),
        .drain_drive (drain_drive)
    );

    // Reference: phase counter modulo 12 plus run/collect flags.
    int m_phase = 0;
    bit m_run = 1'b0;
    bit m_coll = 1'b0;

    always @(posedge clk) begin
        if (rst || !en) begin
            m_phase <= 0;
            m_run   <= 1'b0;
            m_coll  <= 1'b0;
        end else begin
            m_phase <= (m_phase + 1) % PERIOD;
            m_run   <= 1'b1;
            if (m_run && m_phase == PERIOD - 1) m_coll <= win_req;
        end
    end

    function automatic logic [NGATE-1:0] exp_cg();
        logic [NGATE-1:0] v = '0;
        if (m_coll && en && m_phase >= 1 && m_phase <= NGATE) v[m_phase-1] = 1'b1;
        return v;
    endfunction

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h time=%0t", req, act, exp, $time);
        end
    endtask

    task automatic cmp_cycle();
        logic [NGATE-1:0] e;
        e = exp_cg();
        check(cg_drive == e, "R4 R7 R8 cg_drive", int'(cg_drive), int'(e));
        check(drain_drive == !(m_coll && en), "R6 drain_drive",
              int'(drain_drive), int'(!(m_coll && en)));
        check($countones({drain_drive, cg_drive}) <= 1, "R5 onehot",
              $countones({drain_drive, cg_drive}), 1);
    endtask

    // One clock: compare at the falling edge, then drive new inputs.
    task automatic step(input bit e_v, input bit w_v);
        @(negedge clk);
        cmp_cycle();
        en = e_v;
        win_req = w_v;
    endtask

    task automatic finish_run();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog actual=1 expected=0");
            finish_run();
        end
    end

    initial begin
        int gap;
        int last;
        logic [15:0] lfsr;

        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        // R1: reset state at the ports
        check(cg_drive == '0, "R1 cg after reset", int'(cg_drive), 0);
        check(drain_drive == 1'b1, "R1 drain after reset", int'(drain_drive), 1);

        // R2: ring restarts from phase 0 after enable
        for (int i = 0; i < 30; i++) step(1'b1, 1'b1);

        // R3: one strobe per 12 clocks on gate 1
        last = -1;
        gap = 0;
        for (int i = 0; i < 40; i++) begin
            step(1'b1, 1'b1);
            if (cg_drive[0]) begin
                if (last >= 0) check(i - last == PERIOD, "R3 period", i - last, PERIOD);
                last = i;
                gap++;
            end
        end
        check(gap >= 3, "R3 strobe count", gap, 3);

        // R9: dropping enable clears outputs in the same cycle
        while (!cg_drive[1]) step(1'b1, 1'b1);
        @(negedge clk);
        en = 1'b0;
        #1;
        check(cg_drive == '0, "R9 abort cg", int'(cg_drive), 0);
        check(drain_drive == 1'b1, "R9 abort drain", int'(drain_drive), 1);
        for (int i = 0; i < 4; i++) step(1'b0, 1'b1);

        // R7 R8: open and close the window at every phase offset
        for (int open_at = 0; open_at < PERIOD; open_at++) begin
            for (int close_at = 0; close_at < PERIOD; close_at += 3) begin
                step(1'b0, 1'b0);
                for (int i = 0; i < open_at; i++) step(1'b1, 1'b0);
                for (int i = 0; i < PERIOD + 2; i++) step(1'b1, 1'b1);
                for (int i = 0; i < close_at; i++) step(1'b1, 1'b1);
                for (int i = 0; i < PERIOD + 3; i++) step(1'b1, 1'b0);
            end
        end

        // R2 R5 R6: LFSR-driven request with occasional enable drops
        lfsr = 16'hACE1;
        for (int i = 0; i < 4000; i++) begin
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            step(lfsr[7:0] != 8'h00, lfsr[3] ^ lfsr[9]);
        end

        step(1'b0, 1'b0);
        done = 1'b1;
        finish_run();
    end
endmodule